// File: doc/BRIEF.md
# Trackball Motion Delta Read Port

This block turns two free-running 8-bit trackball position counts (one horizontal, one vertical) into a single byte of relative motion for a processor. Each time the processor reads the port, the block returns how far each axis has moved since the previous read. Each distance is cut to a 4-bit wrapped value, and the horizontal value sits in the high nibble. In the same cycle the block stores the present positions as the new reference, so every read clears the motion it reports.

The vertical axis is mounted reversed, so its distance is taken as reference minus current rather than current minus reference. A parameter selects this per axis. The returned byte is registered. It appears on the cycle after the read strobe and holds until the next strobe.

A small controller has two named states. `ST_IDLE` means no read took place on the previous edge, and the data register holds. `ST_FRESH` means a read was taken on the previous edge, and the data register was just reloaded. The transition `take_read` moves from either state to `ST_FRESH` when `rd_stb` is high. The transition `settle` moves from either state to `ST_IDLE` when `rd_stb` is low.

Top module: `trackball_delta_port`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0x00, both stored references are 0, and the controller is in `ST_IDLE`. The first read after reset therefore measures motion from position 0 on both axes.
- R2: On the cycle after a clock edge with `rd_stb` high, `rd_data[7:4]` equals (`pos_x` at that edge minus the X reference) modulo 16.
- R3: With the default vertical reversal, `rd_data[3:0]` on the cycle after a read equals (the Y reference minus `pos_y` at that edge) modulo 16.
- R4: At every edge with `rd_stb` high, the references become the `pos_x` and `pos_y` values sampled at that same edge. A second read with unchanged positions therefore returns 0x00.
- R5: At an edge with `rd_stb` low, `rd_data` keeps its value and the references are unchanged, whatever the position inputs do. After such idle cycles, a later read measures motion from the last read.
- R6: Motion of more than 15 counts between reads wraps modulo 16 with no saturation. Motion in the negative direction wraps the same way: a movement of −1 gives 0xF.
- R7: Strobes on consecutive cycles are each serviced. Each one returns the motion since the strobe before it, and the controller stays in `ST_FRESH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_x | input | 8 | Free-running horizontal position count |
| pos_y | input | 8 | Free-running vertical position count |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | {X delta, Y delta}, valid the cycle after a strobe |

## Verification
The bench uses the defaults: 8-bit positions, 4-bit deltas, X not reversed and Y reversed. With these settings, an 8-bit position count of 255 lies well beyond the 15-count nibble range, so a single step reaches both positive and negative wrap-around of the deltas. The default settings also cover the case where the Y reference sits near 255 while the new position is near 0.

// File: rtl/trackball_delta_pkg.sv
package trackball_delta_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRESH = 1'b1
    } rd_state_t;

endpackage

// File: rtl/tb_axis_delta.sv
module tb_axis_delta #(
    parameter int POS_W   = 8,
    parameter int DELTA_W = 4,
    parameter bit REVERSE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [POS_W-1:0]   pos,
    input  logic               capture,
    output logic [DELTA_W-1:0] delta
);
    logic [POS_W-1:0] ref_q;
    logic [POS_W-1:0] diff;

    // Reference register: loaded with the live position on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (capture) begin
            ref_q <= pos;
        end
    end

    generate
        if (REVERSE) begin : g_rev
            always_comb diff = ref_q - pos;
        end else begin : g_fwd
            always_comb diff = pos - ref_q;
        end
    endgenerate

    assign delta = diff[DELTA_W-1:0];

endmodule

// File: rtl/tb_read_ctrl.sv
module tb_read_ctrl
    import trackball_delta_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] packed_delta,
    output logic              capture,
    output rd_state_t         state,
    output logic [DATA_W-1:0] data_q
);
    rd_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = rd_stb ? ST_FRESH : ST_IDLE;   // take_read / settle
            ST_FRESH: state_nxt = rd_stb ? ST_FRESH : ST_IDLE;   // take_read / settle
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    assign capture = rd_stb;

    // Output register: reloaded only on the edge that enters ST_FRESH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state_nxt == ST_FRESH) begin
            data_q <= packed_delta;
        end
    end

endmodule

// File: rtl/trackball_delta_port.sv
module trackball_delta_port
    import trackball_delta_pkg::*;
#(
    parameter int POS_W     = 8,
    parameter int DELTA_W   = 4,
    parameter bit REVERSE_X = 1'b0,
    parameter bit REVERSE_Y = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [POS_W-1:0]     pos_x,
    input  logic [POS_W-1:0]     pos_y,
    input  logic                 rd_stb,
    output logic [2*DELTA_W-1:0] rd_data
);
    localparam int NUM_AXES = 2;
    localparam int DATA_W   = NUM_AXES * DELTA_W;

    logic [POS_W-1:0]   axis_pos   [NUM_AXES];
    logic [DELTA_W-1:0] axis_delta [NUM_AXES];
    logic [DATA_W-1:0]  packed_delta;
    logic               capture;
    rd_state_t          state;

    // Index 0 = X (high nibble), index 1 = Y (low nibble)
    assign axis_pos[0] = pos_x;
    assign axis_pos[1] = pos_y;

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            tb_axis_delta #(
                .POS_W  (POS_W),
                .DELTA_W(DELTA_W),
                .REVERSE((a == 0) ? REVERSE_X : REVERSE_Y)
            ) u_axis (
                .clk    (clk),
                .rst_n  (rst_n),
                .pos    (axis_pos[a]),
                .capture(capture),
                .delta  (axis_delta[a])
            );
            assign packed_delta[DATA_W-1-a*DELTA_W -: DELTA_W] = axis_delta[a];
        end
    endgenerate

    tb_read_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb      (rd_stb),
        .packed_delta(packed_delta),
        .capture     (capture),
        .state       (state),
        .data_q      (rd_data)
    );

endmodule

// File: rtl/trackball_delta_port_chk.sv
module trackball_delta_port_chk
    import trackball_delta_pkg::*;
#(
    parameter int POS_W   = 8,
    parameter int DELTA_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [POS_W-1:0]     pos_x,
    input logic [POS_W-1:0]     pos_y,
    input logic                 rd_stb,
    input logic [2*DELTA_W-1:0] rd_data,
    input rd_state_t            state
);
    // Shadow references rebuilt from the port activity.
    logic [POS_W-1:0] sh_x, sh_y;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_x <= '0;
            sh_y <= '0;
        end else if (rd_stb) begin
            sh_x <= pos_x;
            sh_y <= pos_y;
        end
    end

    logic [POS_W-1:0] x_move, y_move;
    assign x_move = pos_x - sh_x;
    assign y_move = sh_y - pos_y;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && state == ST_IDLE));

    // R2
    x_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[2*DELTA_W-1:DELTA_W] == $past(x_move[DELTA_W-1:0]));

    // R3
    y_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[DELTA_W-1:0] == $past(y_move[DELTA_W-1:0]));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(rd_data) && state == ST_IDLE));

    // R7
    fresh_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> state == ST_FRESH);

endmodule

bind trackball_delta_port trackball_delta_port_chk #(
    .POS_W  (POS_W),
    .DELTA_W(DELTA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos_x  (pos_x),
    .pos_y  (pos_y),
    .rd_stb (rd_stb),
    .rd_data(rd_data),
    .state  (state)
);

// File: tb/trackball_delta_port_test.sv
module trackball_delta_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {pos_x, pos_y, expected rd_data}; references start at 0/0
    localparam logic [23:0] VEC [NVEC] = '{
        24'h03_00_30,   // R2 plain X step
        24'h03_05_0B,   // R3 Y reversed: 0-5 -> B
        24'h01_02_E3,   // R2 negative X: -2 -> E
        24'h12_FF_13,   // R6 X +17 wraps to 1
        24'h12_FF_00,   // R4 no motion since last read
        24'h11_00_FF,   // R6 -1 on X, Y 255->0
        24'h21_F8_08,   // R6 X +16 -> 0
        24'hA9_38_80    // R2/R3 large moves
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pos_x = '0;
    logic [7:0] pos_y = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trackball_delta_port uut (
        .clk(clk), .rst_n(rst_n), .pos_x(pos_x), .pos_y(pos_y),
        .rd_stb(rd_stb), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%02h expected %02h", req, rd_data, exp);
        end
    endtask

    // Drive at negedge, strobe sampled at posedge, result read at next negedge.
    task automatic do_read(input logic [7:0] x, input logic [7:0] y);
        pos_x = x; pos_y = y; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][23:16], VEC[i][15:8]);
            check((i == 3 || i == 5 || i == 6) ? "R6" :
                  (i == 4) ? "R4" : (i == 1) ? "R3" : "R2", VEC[i][7:0]);
        end

        // R5: positions move without a strobe; data and references hold
        pos_x = 8'hAC; pos_y = 8'h35;
        repeat (3) @(negedge clk);
        check("R5", 8'h80);
        do_read(8'hAC, 8'h35);
        check("R5", 8'h33);

        // R7: back-to-back strobes
        pos_x = 8'hAD; pos_y = 8'h35; rd_stb = 1'b1;
        @(negedge clk);
        check("R7", 8'h10);
        pos_x = 8'hB0;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R7", 8'h30);

        // R1: reset mid-run clears data and references
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h02, 8'h01);
        check("R1", 8'h2F);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: run did not complete, expected done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule